// File: doc/BRIEF.md
# Fast Overrange Threshold Detector

This block sits beside the converter data path and watches each channel's raw 12-bit two's-complement samples. With a fixed two-clock latency it drives four fast-detect bits per channel. The filtered data path is much slower, so these bits let system gain be cut before the converter clips. The four bits can carry a coarse input level, or a set of flags. The flags are an upper-threshold flag that is held for a programmable dwell time, a full-scale overrange flag, and optional extra level or sign detail.

The magnitude is the absolute value of the sample, with the most negative code saturating to full scale. It is compared against a shared threshold. A dwell counter keeps the upper-threshold flag high for a programmable number of clocks after the level drops back below the threshold. This avoids chattering of the gain control on a signal that hovers near the limit. A shared 3-bit mode field selects the meaning of the bits. Every channel runs an identical, independent lane.

Top module: `fast_overrange_detect`

## Requirements
- R1: Every channel's fast-detect bits reflect the sample presented two rising clock edges earlier, in every mode.
- R2: Mode 000: the four bits carry magnitude bits [10:7], where magnitude is the absolute value of the sample.
- R3: The sample 0x800 (-2048) has magnitude 2047, so in mode 000 it gives 1111.
- R4: Modes 001 to 100: bit 0 goes high two clocks after a sample whose magnitude is strictly greater than the 11-bit threshold. A magnitude equal to the threshold does not set it.
- R5: After the last sample above the threshold, bit 0 stays high for exactly `dwell_i` further clocks and then falls. A new sample above the threshold reloads the dwell count.
- R6: Modes 001 to 100: bit 1 is high exactly when the magnitude equals 2047 (samples 2047, -2047 and -2048).
- R7: Modes 001 and 100: bits 3:2 are 0.
- R8: Mode 010: bits 3:2 carry magnitude bits [10:9].
- R9: Mode 011: bit 3 carries the undelayed compare (magnitude greater than threshold, with no dwell) and bit 2 carries the sample sign.
- R10: Codes 101, 110 and 111 drive all four bits to 0.
- R11: While reset is low, and after its release until the first sample above the threshold arrives, the fast-detect bits are 0 with a zero input.
- R12: Channel c uses sample bits [12c+11:12c] and drives fast-detect bits [4c+3:4c]. The channels do not affect each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sample_i | input | NUM_CH*12 | Two's-complement samples, channel c at [12c+11:12c] |
| thresh_i | input | 11 | Upper threshold on magnitude, shared |
| dwell_i | input | DWELL_W | Clocks the flag is held after the level falls, shared |
| mode_i | input | 3 | Fast-detect mode select, shared |
| fd_o | output | NUM_CH*4 | Fast-detect bits, channel c at [4c+3:4c] |

## Verification
The level path is driven with code-boundary samples: ±127/128, ±1023/1024, 2046, 2047, -2047 and -2048. These separate an off-by-one in the magnitude, a missing saturation, and a wrong bit slice. The flag path is driven with magnitudes at threshold minus one, at the threshold, and at threshold plus one, of both signs, which exposes a compare that is not strict. Isolated pulses and retriggered pulses under several dwell values distinguish a correct hold length from one that is one clock short or long, and show whether a retrigger reloads the count. A pseudo-random stream in every mode code, with different data on each channel, checks the bit layout per mode, the reserved codes and lane crosstalk.

// File: rtl/fod_pkg.sv
package fod_pkg;
  localparam int FD_W = 4;

  typedef enum logic [2:0] {
    FD_MODE_LEVEL    = 3'd0,
    FD_MODE_FLAG     = 3'd1,
    FD_MODE_FLAG_LVL = 3'd2,
    FD_MODE_FLAG_RAW = 3'd3,
    FD_MODE_FLAG_ALT = 3'd4
  } fd_mode_e;
endpackage

// File: rtl/fod_mag.sv
module fod_mag #(
  parameter int SAMPLE_W = 12,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  output logic [MAG_W-1:0]    mag_o,
  output logic                sign_o
);
  logic [SAMPLE_W-1:0] neg_s;
  logic [MAG_W-1:0]    mag_d;

  assign neg_s = ~sample_i + 1'b1;

  always_comb begin
    if (!sample_i[SAMPLE_W-1])             mag_d = sample_i[MAG_W-1:0];
    else if (sample_i[MAG_W-1:0] == '0)    mag_d = '1; // most negative code saturates
    else                                   mag_d = neg_s[MAG_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mag_o  <= '0;
      sign_o <= 1'b0;
    end else begin
      mag_o  <= mag_d;
      sign_o <= sample_i[SAMPLE_W-1];
    end
  end
endmodule

// File: rtl/fod_dwell.sv
module fod_dwell #(
  parameter int MAG_W   = 11,
  parameter int DWELL_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAG_W-1:0]   mag_i,
  input  logic [MAG_W-1:0]   thresh_i,
  input  logic [DWELL_W-1:0] dwell_i,
  output logic               flag_o,
  output logic               above_o
);
  logic               above_d;
  logic [DWELL_W-1:0] cnt_q;

  assign above_d = mag_i > thresh_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      flag_o  <= 1'b0;
      above_o <= 1'b0;
    end else begin
      above_o <= above_d;
      if (above_d) begin
        cnt_q  <= dwell_i;
        flag_o <= 1'b1;
      end else if (cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        flag_o <= 1'b1;
      end else begin
        flag_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fod_encode.sv
module fod_encode
  import fod_pkg::*;
#(
  parameter int MAG_W = 11
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [MAG_W-1:0] mag_i,
  input  logic             sign_i,
  input  logic             flag_i,
  input  logic             above_i,
  input  logic [2:0]       mode_i,
  output logic [FD_W-1:0]  fd_o
);
  logic [FD_W-1:0] lvl_q;
  logic            ovr_q;
  logic            sign_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q  <= '0;
      ovr_q  <= 1'b0;
      sign_q <= 1'b0;
    end else begin
      lvl_q  <= mag_i[MAG_W-1 -: FD_W];
      ovr_q  <= &mag_i;
      sign_q <= sign_i;
    end
  end

  always_comb begin
    case (fd_mode_e'(mode_i))
      FD_MODE_LEVEL:    fd_o = lvl_q;
      FD_MODE_FLAG,
      FD_MODE_FLAG_ALT: fd_o = {2'b00, ovr_q, flag_i};
      FD_MODE_FLAG_LVL: fd_o = {lvl_q[FD_W-1 -: 2], ovr_q, flag_i};
      FD_MODE_FLAG_RAW: fd_o = {above_i, sign_q, ovr_q, flag_i};
      default:          fd_o = '0;
    endcase
  end
endmodule

// File: rtl/fod_lane.sv
module fod_lane
  import fod_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int DWELL_W  = 8,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SAMPLE_W-1:0] sample_i,
  input  logic [MAG_W-1:0]    thresh_i,
  input  logic [DWELL_W-1:0]  dwell_i,
  input  logic [2:0]          mode_i,
  output logic [FD_W-1:0]     fd_o
);
  logic [MAG_W-1:0] mag;
  logic             sign, flag, above;

  fod_mag #(.SAMPLE_W(SAMPLE_W)) u_mag (
    .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i),
    .mag_o(mag), .sign_o(sign)
  );

  fod_dwell #(.MAG_W(MAG_W), .DWELL_W(DWELL_W)) u_dwell (
    .clk_i(clk_i), .rst_ni(rst_ni), .mag_i(mag), .thresh_i(thresh_i),
    .dwell_i(dwell_i), .flag_o(flag), .above_o(above)
  );

  fod_encode #(.MAG_W(MAG_W)) u_enc (
    .clk_i(clk_i), .rst_ni(rst_ni), .mag_i(mag), .sign_i(sign),
    .flag_i(flag), .above_i(above), .mode_i(mode_i), .fd_o(fd_o)
  );
endmodule

// File: rtl/fast_overrange_detect.sv
module fast_overrange_detect
  import fod_pkg::*;
#(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int DWELL_W  = 8,
  localparam int MAG_W = SAMPLE_W - 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input  logic [MAG_W-1:0]           thresh_i,
  input  logic [DWELL_W-1:0]         dwell_i,
  input  logic [2:0]                 mode_i,
  output logic [NUM_CH*FD_W-1:0]     fd_o
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_lane
    fod_lane #(.SAMPLE_W(SAMPLE_W), .DWELL_W(DWELL_W)) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sample_i(sample_i[c*SAMPLE_W +: SAMPLE_W]),
      .thresh_i(thresh_i),
      .dwell_i (dwell_i),
      .mode_i  (mode_i),
      .fd_o    (fd_o[c*FD_W +: FD_W])
    );
  end
endmodule

// File: rtl/fod_chk.sv
module fod_chk #(
  parameter int NUM_CH   = 2,
  parameter int SAMPLE_W = 12,
  parameter int DWELL_W  = 8,
  localparam int MAG_W = SAMPLE_W - 1,
  localparam int FDW   = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [NUM_CH*SAMPLE_W-1:0] sample_i,
  input logic [MAG_W-1:0]           thresh_i,
  input logic [DWELL_W-1:0]         dwell_i,
  input logic [2:0]                 mode_i,
  input logic [NUM_CH*FDW-1:0]      fd_o
);
  logic [1:0] age_q;
  logic       live, flag_mode;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 1'b1;
  end

  assign live      = age_q >= 2'd2;
  assign flag_mode = (mode_i >= 3'd1) && (mode_i <= 3'd4);

  function automatic logic [MAG_W-1:0] mag_of(input logic [SAMPLE_W-1:0] s);
    logic [SAMPLE_W-1:0] n;
    n = ~s + 1'b1;
    if (!s[SAMPLE_W-1])          return s[MAG_W-1:0];
    if (s[MAG_W-1:0] == '0)      return '1;
    return n[MAG_W-1:0];
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2
    level_bits_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && mode_i == 3'd0) |->
        fd_o[c*FDW +: FDW] == mag_of($past(sample_i[c*SAMPLE_W +: SAMPLE_W], 2))[MAG_W-1 -: FDW]);
    // R6
    full_scale_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && flag_mode) |->
        fd_o[c*FDW+1] == (mag_of($past(sample_i[c*SAMPLE_W +: SAMPLE_W], 2)) == '1));
    // R4
    upper_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (live && flag_mode &&
       mag_of($past(sample_i[c*SAMPLE_W +: SAMPLE_W], 2)) > $past(thresh_i)) |->
        fd_o[c*FDW]);
    // R7
    spare_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i == 3'd1 || mode_i == 3'd4) |-> fd_o[c*FDW+2 +: 2] == 2'b00);
    // R10
    reserved_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mode_i >= 3'd5) |-> fd_o[c*FDW +: FDW] == '0);
  end
endmodule

bind fast_overrange_detect fod_chk #(
  .NUM_CH(NUM_CH), .SAMPLE_W(SAMPLE_W), .DWELL_W(DWELL_W)
) u_fod_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .sample_i(sample_i), .thresh_i(thresh_i),
  .dwell_i(dwell_i), .mode_i(mode_i), .fd_o(fd_o)
);

// File: tb/fast_overrange_detect_test.sv
module fast_overrange_detect_test;
  localparam int NCH = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] s_v [NCH];
  logic [10:0] thr_v = 11'd1000;
  logic [7:0]  dwell_v = 8'd0;
  logic [2:0]  mode_v = 3'd0;
  logic [NCH*12-1:0] sample;
  logic [NCH*4-1:0]  fd;

  int vectors = 0, errors = 0, edges = 0;
  int m_cnt [NCH];
  int m_flag [NCH];

  typedef struct { int due; logic [11:0] s [NCH]; } item_t;
  item_t q[$];

  always #10 clk = ~clk;

  assign sample = {s_v[1], s_v[0]};

  fast_overrange_detect uut (
    .clk_i(clk), .rst_ni(rst_n), .sample_i(sample), .thresh_i(thr_v),
    .dwell_i(dwell_v), .mode_i(mode_v), .fd_o(fd)
  );

  function automatic int mag_of(logic [11:0] s);
    int v = int'($signed(s));
    if (v == -2048) return 2047;
    return (v < 0) ? -v : v;
  endfunction

  task automatic check(bit ok, string req, int ch, int act, int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s ch%0d: fd=%b expected=%b", req, ch, act[3:0], exp[3:0]);
    end
  endtask

  // driver: one call per clock, pushes the item due two edges later (R1)
  task automatic step(logic [11:0] a, logic [11:0] b);
    item_t it;
    @(negedge clk);
    s_v[0] = a;
    s_v[1] = b;
    it.due = edges + 2;
    it.s[0] = a;
    it.s[1] = b;
    q.push_back(it);
  endtask

  // monitor / scoreboard
  task automatic monitor();
    forever begin
      @(posedge clk);
      edges++;
      #1;
      while (q.size() > 0 && q[0].due == edges) begin
        item_t it = q.pop_front();
        for (int c = 0; c < NCH; c++) begin
          int mag = mag_of(it.s[c]);
          int lvl = mag >> 7;
          int above = (mag > int'(thr_v)) ? 1 : 0;
          int ovr = (mag == 2047) ? 1 : 0;
          int sgn = int'(it.s[c][11]);
          int exp;
          string req;
          if (above != 0) begin
            m_cnt[c] = int'(dwell_v);
            m_flag[c] = 1;
          end else if (m_cnt[c] != 0) begin
            m_cnt[c]--;
            m_flag[c] = 1;
          end else m_flag[c] = 0;
          case (mode_v)
            3'd0: begin exp = lvl; req = (it.s[c] == 12'h800) ? "R3 R1" : "R2 R1"; end
            3'd1, 3'd4: begin exp = ovr*2 + m_flag[c]; req = "R4 R5 R6 R7"; end
            3'd2: begin exp = (lvl >> 2)*4 + ovr*2 + m_flag[c]; req = "R4 R5 R6 R8"; end
            3'd3: begin exp = above*8 + sgn*4 + ovr*2 + m_flag[c]; req = "R4 R5 R6 R9"; end
            default: begin exp = 0; req = "R10"; end
          endcase
          // R12: each lane compared on its own slice
          check(int'(fd[c*4 +: 4]) == exp, req, c, int'(fd[c*4 +: 4]), exp);
        end
      end
    end
  endtask

  task automatic pair_run(logic [11:0] a, int n);
    for (int i = 0; i < n; i++) step(a, 12'h000);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    logic [11:0] lf;
    s_v[0] = '0;
    s_v[1] = '0;
    for (int c = 0; c < NCH; c++) begin m_cnt[c] = 0; m_flag[c] = 0; end
    #35;
    // R11
    check(fd == '0, "R11", 0, int'(fd[3:0]), 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(fd == '0, "R11", 1, int'(fd[7:4]), 0);
    fork monitor(); join_none

    // mode 000: level bits and saturation (R2, R3)
    step(12'd0, 12'd2047);   step(12'd127, 12'd128);
    step(12'd128, 12'd127);  step(12'd1023, 12'd1024);
    step(12'd2047, 12'd0);   step(12'hFFF, 12'h800);
    step(-12'd128, -12'd127); step(-12'd2047, 12'd2046);
    step(12'h800, 12'h801);  step(-12'd1024, -12'd1023);

    // threshold compare boundary, no dwell (R4)
    mode_v = 3'd1; thr_v = 11'd1000; dwell_v = 8'd0;
    step(12'd999, 12'd1001); step(12'd1000, -12'd1000);
    step(12'd1001, -12'd1001); step(12'd1000, 12'd0);
    step(-12'd1001, 12'd1000); step(12'd0, 12'd0);
    step(12'd0, 12'd0);

    // dwell hold length and retrigger (R5)
    dwell_v = 8'd3;
    step(12'd1500, 12'd0); pair_run(12'd0, 6);
    step(12'd1500, 12'd0); step(12'd0, 12'd1500); step(12'd1500, 12'd0);
    pair_run(12'd0, 6);
    dwell_v = 8'd20;
    step(-12'd1500, 12'd0); pair_run(12'd0, 25);

    // full-scale codes (R6) in the alternate flag mode (R7)
    mode_v = 3'd4; dwell_v = 8'd0;
    step(12'd2047, 12'h800); step(-12'd2047, 12'd2046);
    step(12'h800, 12'd2047); step(12'd2046, -12'd2046);
    step(12'd0, 12'd0);      step(12'd0, 12'd0);

    // extra-detail modes (R8, R9)
    mode_v = 3'd2; dwell_v = 8'd2;
    step(12'd1536, 12'd600); step(12'd700, 12'd1100);
    step(12'd0, -12'd1600);  pair_run(12'd300, 4);
    mode_v = 3'd3;
    step(-12'd1200, 12'd5);  step(-12'd5, 12'd1200);
    step(12'd1001, -12'd999); pair_run(-12'd1, 4);

    // pseudo-random sweep over every mode code including reserved (R10, R12)
    thr_v = 11'd1500;
    lf = 12'hACE;
    for (int m = 0; m < 8; m++) begin
      mode_v = 3'(m);
      for (int i = 0; i < 40; i++) begin
        lf = {lf[10:0], lf[11] ^ lf[10] ^ lf[9] ^ lf[3]};
        step(lf, {lf[5:0], lf[11:6]});
      end
    end

    repeat (4) @(posedge clk);
    #3;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule